// File: doc/BRIEF.md
# Colour-Order Door Unlock Controller

This block drives a door release from a small keypad made of one start key and three coloured keys. The door opens only after the start key and then the colour keys red, blue, green and red have been pressed one at a time, in that order. Each key arrives as a clean one-cycle pulse, and a separate flag says that some colour key is down in that cycle. The block leaves the debouncing and the actuator to its neighbours.

The controller is a Moore machine with six states: an idle state, an armed state, three partial-progress states and an open state. A colour press counts as correct only when the expected colour is the single key down. A wrong colour, an extra colour or several colours at once all send the machine back to idle. Holding every key at once therefore never opens the door. Cycles with no colour activity leave the progress unchanged. The release output is high for exactly one cycle.

Top module: `doorcode_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine returns to idle, and `unlock` is 0 in the cycle that follows.
- R2: In idle, colour presses are ignored. The machine leaves idle only on a cycle with `startBtn` = 1, which moves it to armed.
- R3: From armed, single presses of red, blue, green and red, in that order, raise `unlock` in the cycle after the edge that samples the final red press.
- R4: `unlock` is 1 only in the open state. It lasts exactly one cycle, and the machine is then back in idle without any input.
- R5: In armed or in any progress state, a cycle with `anyColour` = 0 holds the current state. Idle gaps of any length between correct presses still end in an unlock.
- R6: A single colour press that is not the expected colour for the current step sends the machine to idle, so a later correct tail does not unlock.
- R7: A press where two or three colour keys are down is treated as wrong, even when the expected colour is among them, and the machine goes to idle.
- R8: Outside idle, `startBtn` has no effect. A start press during a sequence neither restarts nor breaks it.
- R9: Reset takes priority over every transition, including one in the middle of a correct sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| startBtn | input | 1 | Start key pulse |
| redBtn | input | 1 | Red key pulse |
| blueBtn | input | 1 | Blue key pulse |
| greenBtn | input | 1 | Green key pulse |
| anyColour | input | 1 | High in a cycle where at least one colour key is down |
| unlock | output | 1 | Door release, high for one cycle |

## Verification
The assertions assume that `anyColour` equals the OR of the three colour inputs in every cycle. Under that assumption, a cycle with the flag low carries no colour information, and a cycle with the flag high always names at least one key. The stimulus tasks derive the flag from the colour bits they drive, so no cycle ever breaks that relation. The bench drives all inputs on the falling edge and keeps each press to a single cycle. This matches the pulse form that the upstream conditioning logic delivers.

// File: rtl/doorcode_pkg.sv
package doorcode_pkg;

  localparam int STATE_W    = 3;
  localparam int NUM_COLOUR = 3;
  localparam int COLOUR_W   = $clog2(NUM_COLOUR + 1);

  typedef enum logic [COLOUR_W-1:0] {
    COL_RED   = 2'd0,
    COL_BLUE  = 2'd1,
    COL_GREEN = 2'd2,
    COL_NONE  = 2'd3
  } colour_e;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_GOT1  = 3'd2,
    ST_GOT2  = 3'd3,
    ST_GOT3  = 3'd4,
    ST_OPEN  = 3'd5
  } codeState_e;

  // strobes from control to the matcher
  typedef struct packed {
    logic    judge;
    colour_e want;
  } matchReq_t;

  // verdict returned by the matcher
  typedef struct packed {
    logic advance;
    logic reject;
    logic quiet;
  } matchRes_t;

  // colour expected while sitting in a given state
  function automatic colour_e wantFor(codeState_e st);
    case (st)
      ST_ARMED: wantFor = COL_RED;
      ST_GOT1:  wantFor = COL_BLUE;
      ST_GOT2:  wantFor = COL_GREEN;
      ST_GOT3:  wantFor = COL_RED;
      default:  wantFor = COL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/doorcode_match.sv
module doorcode_match
  import doorcode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      redBtn,
  input  logic      blueBtn,
  input  logic      greenBtn,
  input  logic      anyColour,
  input  matchReq_t req,
  output matchRes_t res
);

  logic [NUM_COLOUR-1:0] colourVec;
  logic [NUM_COLOUR-1:0] laneExact;
  logic                  wantHit;

  assign colourVec = {greenBtn, blueBtn, redBtn};

  // a lane is exact when its key is the only one down
  for (genvar i = 0; i < NUM_COLOUR; i++) begin : g_lane
    assign laneExact[i] = colourVec[i] && ($countones(colourVec) == 1);
  end

  always_comb begin
    case (req.want)
      COL_RED:   wantHit = laneExact[0];
      COL_BLUE:  wantHit = laneExact[1];
      COL_GREEN: wantHit = laneExact[2];
      default:   wantHit = 1'b0;
    endcase
  end

  always_comb begin
    res.quiet   = ~anyColour;
    res.advance = req.judge && anyColour && wantHit;
    res.reject  = req.judge && anyColour && !wantHit;
  end

  // R7: several colours down while judging must never advance
  a_r7_multi_rejects: assert property (@(posedge clk) disable iff (rst)
    (req.judge && anyColour && ($countones(colourVec) > 1)) |-> (res.reject && !res.advance));

  // R6: a lone wrong colour while judging is rejected
  a_r6_wrong_rejects: assert property (@(posedge clk) disable iff (rst)
    (req.judge && anyColour && req.want == COL_RED && ($countones(colourVec) == 1) && !redBtn)
      |-> res.reject);

endmodule

// File: rtl/doorcode_ctrl.sv
module doorcode_ctrl
  import doorcode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startBtn,
  input  matchRes_t res,
  output matchReq_t req,
  output logic      unlock
);

  codeState_e curState;
  codeState_e nxtState;
  logic       inProgress;

  assign inProgress = (curState == ST_ARMED) || (curState == ST_GOT1) ||
                      (curState == ST_GOT2)  || (curState == ST_GOT3);

  always_comb begin
    req.judge = inProgress;
    req.want  = wantFor(curState);
  end

  always_comb begin
    nxtState = ST_IDLE;
    case (curState)
      ST_IDLE:  nxtState = startBtn ? ST_ARMED : ST_IDLE;
      ST_ARMED: nxtState = res.advance ? ST_GOT1 : (res.reject ? ST_IDLE : ST_ARMED);
      ST_GOT1:  nxtState = res.advance ? ST_GOT2 : (res.reject ? ST_IDLE : ST_GOT1);
      ST_GOT2:  nxtState = res.advance ? ST_GOT3 : (res.reject ? ST_IDLE : ST_GOT2);
      ST_GOT3:  nxtState = res.advance ? ST_OPEN : (res.reject ? ST_IDLE : ST_GOT3);
      ST_OPEN:  nxtState = ST_IDLE;
      default:  nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nxtState;
  end

  assign unlock = (curState == ST_OPEN);

  // R4: release pulse lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    unlock |=> !unlock);

  // R3: open is reached only from the last progress state
  a_r3_open_from_got3: assert property (@(posedge clk) disable iff (rst)
    (curState != ST_GOT3) |=> (curState != ST_OPEN));

  // R5: a quiet cycle mid-sequence holds the state
  a_r5_quiet_holds: assert property (@(posedge clk) disable iff (rst)
    (inProgress && res.quiet) |=> $stable(curState));

  // R6: a rejected press lands in idle
  a_r6_reject_to_idle: assert property (@(posedge clk) disable iff (rst)
    (inProgress && res.reject) |=> (curState == ST_IDLE));

  // R2: idle without start stays idle
  a_r2_idle_waits: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_IDLE && !startBtn) |=> (curState == ST_IDLE));

endmodule

// File: rtl/doorcode_lock.sv
module doorcode_lock
  import doorcode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic startBtn,
  input  logic redBtn,
  input  logic blueBtn,
  input  logic greenBtn,
  input  logic anyColour,
  output logic unlock
);

  matchReq_t matchReq;
  matchRes_t matchRes;

  doorcode_match match_i (
    .clk       (clk),
    .rst       (rst),
    .redBtn    (redBtn),
    .blueBtn   (blueBtn),
    .greenBtn  (greenBtn),
    .anyColour (anyColour),
    .req       (matchReq),
    .res       (matchRes)
  );

  doorcode_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .startBtn (startBtn),
    .res      (matchRes),
    .req      (matchReq),
    .unlock   (unlock)
  );

endmodule

// File: tb/doorcode_lock_tb_top.sv
`timescale 1ns/1ps
module doorcode_lock_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startBtn = 1'b0;
  logic redBtn = 1'b0;
  logic blueBtn = 1'b0;
  logic greenBtn = 1'b0;
  logic anyColour = 1'b0;
  logic unlock;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int modelStep = 0; // 0 idle, 1 armed, 2..4 partial, 5 open

  always #10 clk = ~clk;

  doorcode_lock dut_i (
    .clk(clk), .rst(rst), .startBtn(startBtn), .redBtn(redBtn),
    .blueBtn(blueBtn), .greenBtn(greenBtn), .anyColour(anyColour),
    .unlock(unlock)
  );

  // 0 red, 1 blue, 2 green
  function automatic int expectIdx(int step);
    case (step)
      1: return 0;
      2: return 1;
      3: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int modelNext(int step, bit rs, bit st, bit rd, bit bl, bit gr);
    bit [2:0] v;
    int n;
    v = {gr, bl, rd};
    n = rd + bl + gr;
    if (rs) return 0;
    if (step == 0) return st ? 1 : 0;
    if (step == 5) return 0;
    if (n == 0) return step;
    if (n == 1 && v[expectIdx(step)]) return step + 1;
    return 0;
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic tick(input bit rs, input bit st, input bit rd, input bit bl,
                      input bit gr, input string tag);
    rst = rs; startBtn = st; redBtn = rd; blueBtn = bl; greenBtn = gr;
    anyColour = rd | bl | gr;
    @(posedge clk);
    modelStep = modelNext(modelStep, rs, st, rd, bl, gr);
    @(negedge clk);
    checks++;
    if (unlock !== (modelStep == 5)) begin
      failures++;
      $display("FAIL %s unlock actual=%b expected=%b at %0t", tag, unlock,
               (modelStep == 5), $time);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, tag);
  endtask

  task automatic press(input int col, input string tag);
    tick(0, 0, col == 0, col == 1, col == 2, tag);
  endtask

  task automatic fullCode(input string tag);
    tick(0, 1, 0, 0, 0, tag);
    press(0, tag); press(1, tag); press(2, tag); press(0, tag);
    idle(2, tag);
  endtask

  initial begin
    @(negedge clk);
    tick(1, 0, 0, 0, 0, "R1");
    tick(1, 1, 1, 1, 1, "R1");
    idle(2, "R1");

    // R3 / R4: correct code, one-cycle release then idle
    fullCode("R3");
    fullCode("R4");

    // R2: colours in idle are ignored, no start -> no release
    press(0, "R2"); press(1, "R2"); press(2, "R2"); press(0, "R2");
    idle(2, "R2");

    // R5 / R8: quiet gaps and stray start presses mid-sequence
    tick(0, 1, 0, 0, 0, "R5");
    idle(3, "R5"); press(0, "R5");
    tick(0, 1, 0, 0, 0, "R8"); press(1, "R8");
    idle(5, "R5"); press(2, "R5");
    tick(0, 1, 0, 0, 0, "R8"); idle(1, "R8");
    press(0, "R5"); idle(2, "R5");

    // R6: a wrong lone colour at each step, then the rest of the code
    for (int k = 0; k < 4; k++) begin
      tick(0, 1, 0, 0, 0, "R6");
      for (int j = 0; j < k; j++) press((j == 1) ? 1 : ((j == 2) ? 2 : 0), "R6");
      press((k == 0 || k == 3) ? 1 : 0, "R6");
      for (int j = k; j < 4; j++) press((j == 1) ? 1 : ((j == 2) ? 2 : 0), "R6");
      idle(2, "R6");
    end

    // R7: several colours together at each step, including the expected one
    for (int k = 0; k < 4; k++) begin
      tick(0, 1, 0, 0, 0, "R7");
      for (int j = 0; j < k; j++) press((j == 1) ? 1 : ((j == 2) ? 2 : 0), "R7");
      if (k == 1) tick(0, 0, 1, 1, 0, "R7");
      else        tick(0, 0, 1, 1, 1, "R7");
      for (int j = k + 1; j < 4; j++) press((j == 1) ? 1 : ((j == 2) ? 2 : 0), "R7");
      idle(2, "R7");
    end
    fullCode("R7");

    // R9: reset in the middle of a correct sequence
    tick(0, 1, 0, 0, 0, "R9");
    press(0, "R9"); press(1, "R9"); press(2, "R9");
    tick(1, 0, 1, 0, 0, "R9");
    press(0, "R9"); idle(2, "R9");
    fullCode("R9");

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule